// File: doc/BRIEF.md
# Colour Palette Lookup with Host Register Port

This block holds a 256-entry colour table in which every entry is a triple of 6-bit components. A host programs and reads the table through a byte-wide port with three registers: a write pointer, a read pointer and a data window. Components go through the data window one at a time, in the order first, second, third. A single position counter, shared by both directions, keeps track of which component is next.

Host writes are collected in a staging buffer. An entry in the table changes only when its third component arrives, and the whole triple is stored in that one step. After every complete triple, in either direction, the pointer that was used moves on by one entry, so a host can stream a run of consecutive entries without reloading the pointer.

The display side takes a pixel code and a mode setting and builds the table index from them. The code is used directly in 256-colour mode. In 16-colour mode the index is formed from a 4-bit colour-select value and the low code bits. The three components of the selected entry come out one clock later, each widened to 8 bits.

Top module: `palette_dac`

## Requirements
- R1: Reset clears the write pointer, the read pointer and the component position to 0, and clears the pixel outputs to 0. After reset, data writes fill entry 0 and data reads start at component 0 of entry 0, with no pointer load needed.
- R2: A host write to register 0 loads the write pointer with all 8 data bits and returns the component position to 0. Any partly staged triple is dropped.
- R3: A data-window write to register 2 is staged and leaves the table unchanged until the third component of the triple arrives.
- R4: On the third data write, the triple is stored at the write pointer, the position returns to 0, and the write pointer increments modulo 256, so entry 255 is followed by entry 0.
- R5: A host write to register 1 loads the read pointer and returns the component position to 0.
- R6: While `host_wr` is low, a host read of register 2 presents on `host_rdata` the component at the current read pointer and position, then advances the position. After the third component, the read pointer increments modulo 256.
- R7: Only data bits 5:0 of a data-window write are stored. On read, bits 7:6 of `host_rdata` are always 0.
- R8: Each 6-bit component v is widened to 8 bits as {v, v[0], v[0]}.
- R9: When `pix_wide` is 1, the table index is `pix_code[7:0]` and `pix_select` has no effect.
- R10: When `pix_wide` is 0 and `pix_split` is 1, the index is {pix_select[3:0], pix_code[3:0]}.
- R11: When `pix_wide` is 0 and `pix_split` is 0, the index is {pix_select[3:2], pix_code[5:0]}.
- R12: The pixel outputs reflect the index inputs sampled at the previous rising clock edge. The pointers and the position change only on a host access, and a write has priority over a read in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_sel | input | 2 | Register select: 0 write pointer, 1 read pointer, 2 data window, 3 unused |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Component at the read pointer and current position, zero-extended |
| pix_code | input | 8 | Pixel code |
| pix_wide | input | 1 | 1 selects 256-colour direct indexing |
| pix_split | input | 1 | In 16-colour mode, 1 uses all four select bits |
| pix_select | input | 4 | Colour-select value |
| pix_r | output | 8 | First component, widened |
| pix_g | output | 8 | Second component, widened |
| pix_b | output | 8 | Third component, widened |

## Verification
The bench reloads the write pointer in the middle of a triple. A design that did not clear the position would store the new bytes in the wrong component slots, or commit after only two bytes. It also rewrites a known entry with two components and then reads the entry back, which shows up any design that writes a component through to the table before the triple is complete. Streams that cross from entry 255 to entry 0 in both directions catch a pointer that saturates or widens instead of wrapping. The two 16-colour index layouts are driven with select and code values whose bits differ in every field, so a swapped or misaligned field lands on the wrong entry.

// File: rtl/palette_dac.sv
module palette_dac #(
  parameter int COMP_W = 6,
  parameter int OUT_W  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic [1:0] host_sel,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  input  logic [7:0] pix_code,
  input  logic       pix_wide,
  input  logic       pix_split,
  input  logic [3:0] pix_select,
  output logic [7:0] pix_r,
  output logic [7:0] pix_g,
  output logic [7:0] pix_b
);
  localparam int ENTRIES = 256;
  localparam int TRI_W   = 3 * COMP_W;
  localparam int PAD_W   = OUT_W - COMP_W;

  localparam logic [1:0] SEL_WIDX = 2'd0;
  localparam logic [1:0] SEL_RIDX = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;

  logic [TRI_W-1:0]  lut [ENTRIES];
  logic [7:0]        widx, ridx;
  logic [1:0]        sub;
  logic [COMP_W-1:0] stg0, stg1;
  logic [TRI_W-1:0]  rd_entry, px_entry;
  logic [COMP_W-1:0] rd_comp;
  logic [7:0]        px_idx;

  wire data_wr = host_wr && host_sel == SEL_DATA;
  wire data_rd = !host_wr && host_rd && host_sel == SEL_DATA;
  wire commit  = data_wr && sub == 2'd2;

  assign rd_entry = lut[ridx];
  assign rd_comp  = (sub == 2'd0) ? rd_entry[TRI_W-1 -: COMP_W] :
                    (sub == 2'd1) ? rd_entry[2*COMP_W-1 -: COMP_W] :
                                    rd_entry[COMP_W-1:0];
  assign host_rdata = {{(8-COMP_W){1'b0}}, rd_comp};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      widx <= '0;
      ridx <= '0;
      sub  <= '0;
      stg0 <= '0;
      stg1 <= '0;
    end else if (host_wr) begin
      case (host_sel)
        SEL_WIDX: begin widx <= host_wdata; sub <= '0; end
        SEL_RIDX: begin ridx <= host_wdata; sub <= '0; end
        SEL_DATA: begin
          if (sub == 2'd0) stg0 <= host_wdata[COMP_W-1:0];
          if (sub == 2'd1) stg1 <= host_wdata[COMP_W-1:0];
          if (sub == 2'd2) begin
            sub  <= '0;
            widx <= widx + 8'd1;
          end else begin
            sub <= sub + 2'd1;
          end
        end
        default: ;
      endcase
    end else if (data_rd) begin
      if (sub == 2'd2) begin
        sub  <= '0;
        ridx <= ridx + 8'd1;
      end else begin
        sub <= sub + 2'd1;
      end
    end
  end

  always_ff @(posedge clk)
    if (commit) lut[widx] <= {stg0, stg1, host_wdata[COMP_W-1:0]};

  assign px_idx = pix_wide  ? pix_code :
                  pix_split ? {pix_select, pix_code[3:0]} :
                              {pix_select[3:2], pix_code[5:0]};
  assign px_entry = lut[px_idx];

  function automatic logic [OUT_W-1:0] widen(input logic [COMP_W-1:0] v);
    return {v, {PAD_W{v[0]}}};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_r <= '0;
      pix_g <= '0;
      pix_b <= '0;
    end else begin
      pix_r <= widen(px_entry[TRI_W-1 -: COMP_W]);
      pix_g <= widen(px_entry[2*COMP_W-1 -: COMP_W]);
      pix_b <= widen(px_entry[COMP_W-1:0]);
    end
  end
endmodule

// File: rtl/palette_dac_chk.sv
module palette_dac_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       host_wr,
  input logic       host_rd,
  input logic [1:0] host_sel,
  input logic [7:0] host_wdata,
  input logic [7:0] host_rdata,
  input logic [7:0] widx,
  input logic [7:0] ridx,
  input logic [1:0] sub
);
  AST_WIDX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && host_sel == 2'd0 |=> widx == $past(host_wdata) && sub == 2'd0); // R2

  AST_RIDX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && host_sel == 2'd1 |=> ridx == $past(host_wdata) && sub == 2'd0); // R5

  AST_COMMIT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && host_sel == 2'd2 && sub == 2'd2 |=> widx == 8'($past(widx) + 8'd1) && sub == 2'd0); // R4

  AST_READ_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    !host_wr && host_rd && host_sel == 2'd2 && sub == 2'd2 |=> ridx == 8'($past(ridx) + 8'd1) && sub == 2'd0); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !host_wr && !host_rd |=> $stable(widx) && $stable(ridx) && $stable(sub)); // R12

  AST_RDATA_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    host_rdata[7:6] == 2'b00); // R7
endmodule

bind palette_dac palette_dac_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
  .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
  .widx(widx), .ridx(ridx), .sub(sub)
);

// File: tb/palette_dac_bench.sv
module palette_dac_bench;
  localparam int CLK_NS = 20;

  logic clk = 0, rst_n = 0;
  logic host_wr = 0, host_rd = 0;
  logic [1:0] host_sel = 0;
  logic [7:0] host_wdata = 0, host_rdata;
  logic [7:0] pix_code = 0;
  logic pix_wide = 1, pix_split = 0;
  logic [3:0] pix_select = 0;
  logic [7:0] pix_r, pix_g, pix_b;

  int checks = 0, errors = 0;

  palette_dac u_palette_dac (.*);

  always #(CLK_NS/2) clk = ~clk;

  // {index, c0, c1, c2}
  localparam logic [25:0] VEC [8] = '{
    {8'h10, 6'h3f, 6'h00, 6'h15},
    {8'h11, 6'h01, 6'h2a, 6'h3e},
    {8'h42, 6'h20, 6'h10, 6'h08},
    {8'h7f, 6'h33, 6'h0c, 6'h01},
    {8'h80, 6'h00, 6'h3f, 6'h02},
    {8'hc3, 6'h1d, 6'h23, 6'h3f},
    {8'he0, 6'h07, 6'h38, 6'h11},
    {8'h01, 6'h2b, 6'h14, 6'h00}
  };

  function automatic logic [7:0] wid(input logic [5:0] v);
    return {v, v[0], v[0]};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hw(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1; host_sel = s; host_wdata = d;
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic hr(output logic [7:0] d);
    @(negedge clk);
    host_rd = 1; host_sel = 2'd2;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 0;
  endtask

  task automatic rd_chk(input string tag, input logic [5:0] exp);
    logic [7:0] d;
    hr(d);
    chk(tag, d, {2'b00, exp});
  endtask

  task automatic look(input logic [7:0] code, input logic wide, input logic split,
                      input logic [3:0] sel, output logic [23:0] rgb);
    @(negedge clk);
    pix_code = code; pix_wide = wide; pix_split = split; pix_select = sel;
    @(negedge clk);
    rgb = {pix_r, pix_g, pix_b};
  endtask

  initial begin
    #(CLK_NS * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [23:0] rgb;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: outputs cleared, pointers at 0
    chk("R1 pix reset", {pix_r, pix_g, pix_b}, 0);
    hw(2, 8'h01); hw(2, 8'h02); hw(2, 8'h03);
    rd_chk("R1 read c0", 6'h01);
    rd_chk("R1 read c1", 6'h02);
    rd_chk("R1 read c2", 6'h03);

    // table walk: R4 R6 R8 R9
    for (int i = 0; i < 8; i++) begin
      hw(0, VEC[i][25:18]);
      hw(2, {2'b00, VEC[i][17:12]});
      hw(2, {2'b00, VEC[i][11:6]});
      hw(2, {2'b00, VEC[i][5:0]});
    end
    for (int i = 0; i < 8; i++) begin
      hw(1, VEC[i][25:18]);
      rd_chk("R6 c0", VEC[i][17:12]);
      rd_chk("R6 c1", VEC[i][11:6]);
      rd_chk("R6 c2", VEC[i][5:0]);
      look(VEC[i][25:18], 1'b1, 1'b0, 4'hf, rgb);
      chk("R8 R9 lookup", rgb, {wid(VEC[i][17:12]), wid(VEC[i][11:6]), wid(VEC[i][5:0])});
    end

    // R7: upper bits dropped
    hw(0, 8'h30); hw(2, 8'hc5); hw(2, 8'h80); hw(2, 8'h7f);
    hw(1, 8'h30);
    rd_chk("R7 c0", 6'h05); rd_chk("R7 c1", 6'h00); rd_chk("R7 c2", 6'h3f);

    // R3: partial triple not committed
    hw(0, 8'h30); hw(2, 8'h11); hw(2, 8'h22);
    hw(1, 8'h30);
    rd_chk("R3 c0", 6'h05); rd_chk("R3 c1", 6'h00); rd_chk("R3 c2", 6'h3f);

    // R2: reload mid-triple restarts at component 0
    hw(0, 8'h20); hw(2, 8'h11);
    hw(0, 8'h20); hw(2, 8'h01); hw(2, 8'h02); hw(2, 8'h03);
    hw(1, 8'h20);
    rd_chk("R2 c0", 6'h01); rd_chk("R2 c1", 6'h02); rd_chk("R2 c2", 6'h03);

    // R5: read reload mid-triple restarts at component 0
    hw(1, 8'h20); rd_chk("R5 first", 6'h01);
    hw(1, 8'h20); rd_chk("R5 restart", 6'h01);

    // R4 / R6: wrap 255 -> 0
    hw(0, 8'hff);
    hw(2, 8'h0a); hw(2, 8'h0b); hw(2, 8'h0c);
    hw(2, 8'h1a); hw(2, 8'h1b); hw(2, 8'h1c);
    hw(1, 8'hff);
    rd_chk("R4 e255 c0", 6'h0a); rd_chk("R4 e255 c1", 6'h0b); rd_chk("R4 e255 c2", 6'h0c);
    rd_chk("R6 wrap c0", 6'h1a); rd_chk("R6 wrap c1", 6'h1b); rd_chk("R6 wrap c2", 6'h1c);

    // R10 / R11: 16-colour index layouts
    hw(0, 8'h5a); hw(2, 8'h3c); hw(2, 8'h03); hw(2, 8'h21);
    hw(0, 8'h9a); hw(2, 8'h12); hw(2, 8'h34); hw(2, 8'h2d);
    look(8'h3a, 1'b0, 1'b1, 4'h5, rgb);
    chk("R10 split index", rgb, {wid(6'h3c), wid(6'h03), wid(6'h21)});
    look(8'h1a, 1'b0, 1'b0, 4'ha, rgb);
    chk("R11 default index", rgb, {wid(6'h12), wid(6'h34), wid(6'h2d)});
    look(8'h5a, 1'b1, 1'b1, 4'h0, rgb);
    chk("R9 select ignored", rgb, {wid(6'h3c), wid(6'h03), wid(6'h21)});

    // R12: one-cycle latency, output holds old value before the edge
    look(8'h9a, 1'b1, 1'b0, 4'h0, rgb);
    @(negedge clk);
    pix_code = 8'h5a;
    #1 chk("R12 before edge", {pix_r, pix_g, pix_b}, {wid(6'h12), wid(6'h34), wid(6'h2d)});
    @(negedge clk);
    chk("R12 after edge", {pix_r, pix_g, pix_b}, {wid(6'h3c), wid(6'h03), wid(6'h21)});

    // R12: write wins over simultaneous read
    hw(1, 8'h20);
    @(negedge clk);
    host_wr = 1; host_rd = 1; host_sel = 2'd1; host_wdata = 8'h5a;
    @(negedge clk);
    host_wr = 0; host_rd = 0;
    rd_chk("R12 write priority", 6'h3c);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule